// File: doc/BRIEF.md
# Strided Tile Address Sequencer

This block produces the memory addresses a transfer engine needs to pull one column tile out of a matrix block held row-major in a source buffer. The buffer holds `p` rows of full width `n`. The tile for destination `j` is the `q` columns beginning at column `j*q`. After a start pulse the sequencer emits one address per accepted handshake until all `p*q` elements are covered. It flags the final address and then pulses a completion strobe.

There are two scan orders, and the order is latched at start. Row scan walks each tile row left to right before stepping down. Column scan walks each tile column top to bottom before stepping right. Column scan hands the tile to the consumer already transposed, so no processor has to rearrange it locally. The engine downstream applies back-pressure with a ready input.

Top module: `tile_addr_seq`

## Requirements
- R1: While reset is asserted and right after it, `valid_o`, `last_o` and `done_o` are low.
- R2: A start accepted while idle latches base, tile index, sizes and scan order. The first address, `base_i + tile_idx_i*cols_i`, appears with `valid_o` high in the cycle after the start edge.
- R3: With `col_scan_i`=0 at start, element (r,c) has address base + j*q + r*n + c. The order is r outer (0..p-1) and c inner (0..q-1).
- R4: With `col_scan_i`=1 at start, the same addresses are produced with c outer (0..q-1) and r inner (0..p-1).
- R5: A run presents exactly p*q distinct addresses. `last_o` is high with the final one and with no other.
- R6: The sequence advances only on a cycle where `valid_o` and `ready_i` are both high. While stalled, the address and `last_o` hold.
- R7: `done_o` is high for exactly one cycle, the cycle after the final address is accepted, and `valid_o` is low in that cycle.
- R8: A start pulse that arrives while a run is in progress is ignored. The run keeps its latched parameters and order.
- R9: A start with `rows_i`=0 or `cols_i`=0 is ignored: `valid_o` and `done_o` stay low.
- R10: Address arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Begin a run (used only when idle) |
| base_i | input | ADDR_W | Buffer base address |
| tile_idx_i | input | DIM_W | Zero-based destination tile index j |
| rows_i | input | DIM_W | Tile rows p |
| cols_i | input | DIM_W | Tile columns q |
| stride_i | input | DIM_W | Full row width n |
| col_scan_i | input | 1 | 1 selects column (transposing) scan |
| ready_i | input | 1 | Consumer accepts the current address |
| addr_o | output | ADDR_W | Element address |
| valid_o | output | 1 | Address is valid |
| last_o | output | 1 | Current address is the final one of the run |
| done_o | output | 1 | One-cycle completion pulse |

## Verification
The first address is due one clock after the start edge. Each further address is due one clock after the edge that accepted its predecessor. `done_o` is due one clock after the final acceptance and drops on the next clock. The bench drives inputs on falling edges and compares outputs on the following falling edge, which is half a period after the only register update that can change them. It advances its expected element index only when it drove ready high for the edge in between. The bench sweeps every tile size from 1x1 to 4x4, every tile index and both scan orders, under both stall-free and stalling ready patterns. Further runs cover ignored starts and address wrap.

// File: rtl/tile_addr_pkg.sv
package tile_addr_pkg;
  typedef enum logic {
    SCAN_ROWS = 1'b0,
    SCAN_COLS = 1'b1
  } scan_mode_e;
endpackage

// File: rtl/tile_loop_ctr.sv
module tile_loop_ctr #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         adv_i,
  input  logic [W-1:0] limit_i,
  output logic [W-1:0] cnt_o,
  output logic         at_end_o
);
  logic [W-1:0] cnt_q, cnt_d;

  assign at_end_o = (cnt_q == limit_i - W'(1));
  assign cnt_o    = cnt_q;

  always_comb begin
    cnt_d = cnt_q;
    if (clr_i)       cnt_d = '0;
    else if (adv_i)  cnt_d = at_end_o ? '0 : cnt_q + W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                cnt_q <= '0;
    else if (clr_i || adv_i)   cnt_q <= cnt_d;
  end

  // R5: the loop index never leaves its range
  p_cnt_in_range_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (limit_i != '0) |-> (cnt_q < limit_i));
endmodule

// File: rtl/tile_addr_step.sv
module tile_addr_step #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_i,
  input  logic [AW-1:0] load_addr_i,
  input  logic          adv_i,
  input  logic          line_end_i,
  input  logic [AW-1:0] inner_step_i,
  input  logic [AW-1:0] outer_step_i,
  output logic [AW-1:0] addr_o
);
  logic [AW-1:0] line_q, line_d, addr_q, addr_d;

  always_comb begin
    line_d = line_q;
    addr_d = addr_q;
    if (load_i) begin
      line_d = load_addr_i;
      addr_d = load_addr_i;
    end else if (adv_i) begin
      if (line_end_i) begin
        line_d = line_q + outer_step_i;
        addr_d = line_q + outer_step_i;
      end else begin
        addr_d = addr_q + inner_step_i;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      line_q <= '0;
      addr_q <= '0;
    end else if (load_i || adv_i) begin
      line_q <= line_d;
      addr_q <= addr_d;
    end
  end

  assign addr_o = addr_q;

  // R6: without a load or an advance the address does not move
  p_addr_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!load_i && !adv_i) |=> $stable(addr_q));
endmodule

// File: rtl/tile_addr_seq.sv
module tile_addr_seq
  import tile_addr_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DIM_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] base_i,
  input  logic [DIM_W-1:0]  tile_idx_i,
  input  logic [DIM_W-1:0]  rows_i,
  input  logic [DIM_W-1:0]  cols_i,
  input  logic [DIM_W-1:0]  stride_i,
  input  logic              col_scan_i,
  input  logic              ready_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic              valid_o,
  output logic              last_o,
  output logic              done_o
);
  localparam int PROD_W = 2 * DIM_W;

  scan_mode_e       mode_q;
  logic [DIM_W-1:0] rows_q, cols_q, stride_q;
  logic             valid_q, valid_d, done_q;
  logic             start_ok, accept, fin;
  logic [PROD_W-1:0] offset;
  logic [ADDR_W-1:0] first_addr, in_step, out_step;
  logic [DIM_W-1:0]  in_lim, out_lim, in_cnt, out_cnt;
  logic              in_end, out_end;

  assign start_ok   = start_i && !valid_q && (rows_i != '0) && (cols_i != '0);
  assign accept     = valid_q && ready_i;
  assign fin        = in_end && out_end;
  assign offset     = PROD_W'(tile_idx_i) * PROD_W'(cols_i);
  assign first_addr = base_i + ADDR_W'(offset);

  always_comb begin
    if (mode_q == SCAN_COLS) begin
      in_lim   = rows_q;
      out_lim  = cols_q;
      in_step  = ADDR_W'(stride_q);
      out_step = ADDR_W'(1);
    end else begin
      in_lim   = cols_q;
      out_lim  = rows_q;
      in_step  = ADDR_W'(1);
      out_step = ADDR_W'(stride_q);
    end
  end

  always_comb begin
    valid_d = valid_q;
    if (start_ok)           valid_d = 1'b1;
    else if (accept && fin) valid_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid_q <= 1'b0;
      done_q  <= 1'b0;
    end else begin
      valid_q <= valid_d;
      done_q  <= accept && fin;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q   <= SCAN_ROWS;
      rows_q   <= '0;
      cols_q   <= '0;
      stride_q <= '0;
    end else if (start_ok) begin
      mode_q   <= scan_mode_e'(col_scan_i);
      rows_q   <= rows_i;
      cols_q   <= cols_i;
      stride_q <= stride_i;
    end
  end

  tile_loop_ctr #(.W(DIM_W)) u_inner (
    .clk(clk), .rst_n(rst_n), .clr_i(start_ok), .adv_i(accept),
    .limit_i(in_lim), .cnt_o(in_cnt), .at_end_o(in_end)
  );

  tile_loop_ctr #(.W(DIM_W)) u_outer (
    .clk(clk), .rst_n(rst_n), .clr_i(start_ok), .adv_i(accept && in_end),
    .limit_i(out_lim), .cnt_o(out_cnt), .at_end_o(out_end)
  );

  tile_addr_step #(.AW(ADDR_W)) u_step (
    .clk(clk), .rst_n(rst_n), .load_i(start_ok), .load_addr_i(first_addr),
    .adv_i(accept), .line_end_i(in_end), .inner_step_i(in_step),
    .outer_step_i(out_step), .addr_o(addr_o)
  );

  assign valid_o = valid_q;
  assign last_o  = valid_q && fin;
  assign done_o  = done_q;

  p_hold_on_stall_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !ready_i) |=> (valid_o && $stable(addr_o) && $stable(last_o)));
  p_done_after_last_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && ready_i && last_o) |=> (done_o && !valid_o));
  p_done_single_r7: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |=> !done_o);
  p_busy_keeps_run_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (valid_o && !(ready_i && last_o)) |=> valid_o);
  p_zero_start_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (!valid_o && start_i && (rows_i == '0 || cols_i == '0)) |=> !valid_o);
  p_last_needs_valid_r5: assert property (@(posedge clk) disable iff (!rst_n)
    last_o |-> valid_o);
  p_step_bounds_r5: assert property (@(posedge clk) disable iff (!rst_n)
    valid_o |-> (in_cnt < in_lim && out_cnt < out_lim));
endmodule

// File: tb/tile_addr_seq_tb.sv
module tile_addr_seq_tb;
  localparam int AW = 16;
  localparam int DW = 8;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          start_i, col_scan_i, ready_i;
  logic [AW-1:0] base_i;
  logic [DW-1:0] tile_idx_i, rows_i, cols_i, stride_i;
  logic [AW-1:0] addr_o;
  logic          valid_o, last_o, done_o;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  int wd = 0;

  always #2 clk = ~clk;

  tile_addr_seq #(.ADDR_W(AW), .DIM_W(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .base_i(base_i),
    .tile_idx_i(tile_idx_i), .rows_i(rows_i), .cols_i(cols_i),
    .stride_i(stride_i), .col_scan_i(col_scan_i), .ready_i(ready_i),
    .addr_o(addr_o), .valid_o(valid_o), .last_o(last_o), .done_o(done_o)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic run(input int base, input int j, input int p, input int q,
                     input int n, input bit tr, input int stall, input bit poke);
    int k = 0;
    bit poked = 1'b0;
    @(negedge clk);
    base_i = AW'(base); tile_idx_i = DW'(j); rows_i = DW'(p);
    cols_i = DW'(q); stride_i = DW'(n); col_scan_i = tr;
    start_i = 1'b1; ready_i = 1'b0;
    @(negedge clk);
    start_i = 1'b0;
    while (k < p * q) begin
      int r, c, exp;
      bit rdy;
      if (tr) begin c = k / p; r = k % p; end
      else    begin r = k / q; c = k % q; end
      exp = (base + j * q + r * n + c) & 16'hFFFF;
      check(valid_o === 1'b1, "R2 valid during run", int'(valid_o), 1);
      check(addr_o === AW'(exp), tr ? "R4 column-scan address" : "R3 row-scan address",
            int'(addr_o), exp);
      check(last_o === (k == p * q - 1), "R5 last flag", int'(last_o), int'(k == p * q - 1));
      cyc++;
      rdy = (stall == 0) ? 1'b1 : (((k + cyc) % 3) != 0);
      if (poke && k == 1 && !poked) begin
        // R8: start while busy with different parameters
        poked = 1'b1;
        start_i = 1'b1; base_i = 16'h1234; rows_i = 8'd2; cols_i = 8'd3;
        tile_idx_i = 8'd1; col_scan_i = ~tr;
      end else begin
        start_i = 1'b0;
      end
      ready_i = rdy;
      @(negedge clk);
      if (rdy) k++;
    end
    start_i = 1'b0;
    ready_i = 1'b0;
    check(done_o === 1'b1, "R7 done after final accept", int'(done_o), 1);
    check(valid_o === 1'b0, "R7 valid low at done", int'(valid_o), 0);
    @(negedge clk);
    check(done_o === 1'b0, "R7 done single cycle", int'(done_o), 0);
  endtask

  always @(posedge clk) begin
    wd++;
    if (wd > 150000) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; start_i = 1'b0; ready_i = 1'b0; col_scan_i = 1'b0;
    base_i = '0; tile_idx_i = '0; rows_i = '0; cols_i = '0; stride_i = '0;
    repeat (3) @(negedge clk);
    check(valid_o === 1'b0 && last_o === 1'b0 && done_o === 1'b0,
          "R1 reset outputs low", int'({valid_o, last_o, done_o}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(valid_o === 1'b0 && done_o === 1'b0, "R1 idle after reset",
          int'({valid_o, done_o}), 0);

    // R3 R4 R5 R6: sweep of tile sizes, tile indices, orders and stall patterns
    for (int p = 1; p <= 4; p++)
      for (int q = 1; q <= 4; q++)
        for (int j = 0; j < 4; j++)
          for (int m = 0; m < 2; m++)
            run(16'h0100 + j * 16, j, p, q, 4 * q, m[0], (p + q + j) % 2, 1'b0);

    // R8: busy starts ignored in both orders
    run(16'h0200, 2, 3, 4, 16, 1'b0, 1, 1'b1);
    run(16'h0300, 1, 4, 3, 12, 1'b1, 1, 1'b1);

    // R10: wrap of address arithmetic
    run(16'hFFF0, 3, 3, 4, 16, 1'b0, 0, 1'b0);
    run(16'hFFF8, 3, 3, 4, 16, 1'b1, 1, 1'b0);

    // R9: zero-sized starts ignored
    for (int z = 0; z < 2; z++) begin
      @(negedge clk);
      rows_i = (z == 0) ? 8'd0 : 8'd3; cols_i = (z == 0) ? 8'd2 : 8'd0;
      stride_i = 8'd8; start_i = 1'b1; ready_i = 1'b1;
      @(negedge clk);
      start_i = 1'b0;
      for (int w = 0; w < 3; w++) begin
        check(valid_o === 1'b0 && done_o === 1'b0, "R9 zero size start ignored",
              int'({valid_o, done_o}), 0);
        @(negedge clk);
      end
    end

    // R2: a run started after an ignored start still begins normally
    run(16'h0040, 0, 1, 1, 4, 1'b0, 0, 1'b0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule